// File: doc/BRIEF.md
# Decode-Stage Instruction Pair Fusion Detector

This block sits in the decode stage of a 64-bit RISC-V core. Each cycle it looks at two adjacent 32-bit instruction words from the fetch stream, the older one and the younger one. It decides whether the two form one of six known idioms that the back end can treat as a single operation. A fusible pair must be linked through one register: the younger instruction overwrites the older one's destination, and it uses that same register as its source.

Software or a mode controller supplies a six-bit mask that switches each idiom on or off. The result is registered, so it appears one cycle after the inputs. It has three parts: a fuse flag, a three-bit idiom code and the shared destination register. Compressed instructions are not examined. Executing or steering the fused pair is left to the stages that follow.

Top module: `fuse_pair_detect`

## Requirements
- R1: An older LUI (opcode 0110111) followed by ADDI (opcode 0010011, funct3 000) or ADDIW (opcode 0011011, funct3 000) fuses with code 1. Mask bit 0 enables it.
- R2: An older AUIPC (opcode 0010111) followed by ADDI fuses with code 2. Mask bit 1 enables it. AUIPC followed by ADDIW never fuses.
- R3: An SLLI (opcode 0010011, funct3 001, bits 31:26 zero, shift amount in bits 25:20) by 48 followed by an SRLI (funct3 101, bits 31:26 zero) by 48 fuses with code 3. Mask bit 2 enables it.
- R4: An SLLI by 32 followed by an SRLI by exactly 32 fuses with code 4. Mask bit 3 enables it.
- R5: An SLLI by 32 followed by an SRLI by 0 to 31 fuses with code 5. Mask bit 4 enables it. An SRLI amount above 32 does not fuse.
- R6: An ADD (opcode 0110011, funct3 000, funct7 0000000) followed by an LD (opcode 0000011, funct3 011) with a zero offset fuses with code 6. Mask bit 5 enables it. A nonzero offset does not fuse.
- R7: A pair fuses only if the younger instruction's rd (bits 11:7) and rs1 (bits 19:15) both equal the older instruction's rd.
- R8: When a pattern's mask bit is low, that pattern never raises the fuse flag.
- R9: There is no fusion when the shared register is x0, or when either valid bit is low.
- R10: Outputs appear one clock after the inputs. When the flag is low, the code and the register output are both zero. When the flag is high, the register output is the older instruction's rd.
- R11: A synchronous active-high reset clears the flag, the code and the register output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| older_insn | input | 32 | Earlier instruction of the pair |
| older_vld | input | 1 | Older word is valid |
| younger_insn | input | 32 | Later instruction of the pair |
| younger_vld | input | 1 | Younger word is valid |
| pat_en | input | 6 | Per-idiom enable, bit i enables code i+1 |
| fuse_o | output | 1 | Registered fuse flag |
| pat_o | output | 3 | Registered idiom code, 0 when not fused |
| rd_o | output | 5 | Registered shared destination register |

## Verification
The exact word zero extension (R4) and the shifted word zero extension (R5) share the same older instruction, an SLLI by 32. A single older word therefore reaches both detectors in the same cycle. The bench holds that SLLI and feeds younger SRLIs with amounts 31, 32 and 33. It expects code 5, then code 4, then no fusion, so a wrong range boundary or an overlap between the two detectors shows up at once. It also clears one of the two mask bits while the other is set, to show that each mask bit gates only its own code.

// File: rtl/fuse_pair_detect.sv
module fuse_pair_detect #(
  parameter int PAT_W = 3,
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      older_insn,
  input  logic             older_vld,
  input  logic [31:0]      younger_insn,
  input  logic             younger_vld,
  input  logic [5:0]       pat_en,
  output logic             fuse_o,
  output logic [PAT_W-1:0] pat_o,
  output logic [REG_W-1:0] rd_o
);
  localparam int NPAT = 6;
  localparam logic [6:0] OP_LUI   = 7'b0110111;
  localparam logic [6:0] OP_AUIPC = 7'b0010111;
  localparam logic [6:0] OP_IMM   = 7'b0010011;
  localparam logic [6:0] OP_IMMW  = 7'b0011011;
  localparam logic [6:0] OP_REG   = 7'b0110011;
  localparam logic [6:0] OP_LOAD  = 7'b0000011;

  logic [6:0]       a_op, b_op;
  logic [2:0]       a_f3, b_f3;
  logic [REG_W-1:0] a_rd, b_rd, b_rs1;
  logic [5:0]       a_sh, b_sh;

  assign a_op  = older_insn[6:0];
  assign b_op  = younger_insn[6:0];
  assign a_f3  = older_insn[14:12];
  assign b_f3  = younger_insn[14:12];
  assign a_rd  = older_insn[11:7];
  assign b_rd  = younger_insn[11:7];
  assign b_rs1 = younger_insn[19:15];
  assign a_sh  = older_insn[25:20];
  assign b_sh  = younger_insn[25:20];

  logic linked;
  assign linked = older_vld && younger_vld && (a_rd != '0) &&
                  (b_rd == a_rd) && (b_rs1 == a_rd);

  logic a_lui, a_auipc, a_slli, a_add, b_addi, b_addiw, b_srli, b_ld;
  assign a_lui   = a_op == OP_LUI;
  assign a_auipc = a_op == OP_AUIPC;
  assign a_slli  = a_op == OP_IMM && a_f3 == 3'b001 && older_insn[31:26] == 6'd0;
  assign a_add   = a_op == OP_REG && a_f3 == 3'b000 && older_insn[31:25] == 7'd0;
  assign b_addi  = b_op == OP_IMM && b_f3 == 3'b000;
  assign b_addiw = b_op == OP_IMMW && b_f3 == 3'b000;
  assign b_srli  = b_op == OP_IMM && b_f3 == 3'b101 && younger_insn[31:26] == 6'd0;
  assign b_ld    = b_op == OP_LOAD && b_f3 == 3'b011;

  logic [NPAT-1:0] hit, live;
  assign hit[0] = a_lui && (b_addi || b_addiw);
  assign hit[1] = a_auipc && b_addi;
  assign hit[2] = a_slli && a_sh == 6'd48 && b_srli && b_sh == 6'd48;
  assign hit[3] = a_slli && a_sh == 6'd32 && b_srli && b_sh == 6'd32;
  assign hit[4] = a_slli && a_sh == 6'd32 && b_srli && b_sh < 6'd32;
  assign hit[5] = a_add && b_ld && younger_insn[31:20] == 12'd0;
  assign live   = hit & pat_en & {NPAT{linked}};

  logic [PAT_W-1:0] pat_d;
  always_comb begin
    pat_d = '0;
    for (int i = 0; i < NPAT; i++)
      if (live[i]) pat_d = PAT_W'(i + 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fuse_o <= 1'b0;
      pat_o  <= '0;
      rd_o   <= '0;
    end else begin
      fuse_o <= |live;
      pat_o  <= pat_d;
      rd_o   <= (|live) ? a_rd : '0;
    end
  end

  generate
    for (genvar g = 0; g < NPAT; g++) begin : g_en_chk
      assert_masked_R8: assert property (@(posedge clk) disable iff (rst)
        (fuse_o && pat_o == PAT_W'(g + 1)) |-> $past(pat_en[g]));
    end
  endgenerate

  assert_valid_x0_R9: assert property (@(posedge clk) disable iff (rst)
    fuse_o |-> ($past(older_vld && younger_vld) && rd_o != '0));
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (rst)
    fuse_o |-> (rd_o == $past(older_insn[11:7]) && pat_o != '0));
  assert_link_R7: assert property (@(posedge clk) disable iff (rst)
    fuse_o |-> ($past(younger_insn[19:15]) == rd_o && $past(younger_insn[11:7]) == rd_o));
  assert_no_addiw_R2: assert property (@(posedge clk) disable iff (rst)
    (fuse_o && pat_o == 3'd2) |-> $past(younger_insn[6:0]) == 7'b0010011);
  assert_half_amt_R3: assert property (@(posedge clk) disable iff (rst)
    (fuse_o && pat_o == 3'd3) |-> ($past(older_insn[25:20]) == 6'd48 && $past(younger_insn[25:20]) == 6'd48));
  assert_zero_off_R6: assert property (@(posedge clk) disable iff (rst)
    (fuse_o && pat_o == 3'd6) |-> $past(younger_insn[31:20]) == 12'd0);
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !fuse_o |-> (pat_o == '0 && rd_o == '0));
endmodule

// File: tb/tb_fuse_pair_detect.sv
`timescale 1ns/1ps
module tb_fuse_pair_detect;
  logic clk = 1'b0, rst = 1'b1;
  logic [31:0] older_insn = '0, younger_insn = '0;
  logic older_vld = 1'b0, younger_vld = 1'b0;
  logic [5:0] pat_en = '0;
  logic fuse_o;
  logic [2:0] pat_o;
  logic [4:0] rd_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fuse_pair_detect dut (.clk(clk), .rst(rst), .older_insn(older_insn), .older_vld(older_vld),
    .younger_insn(younger_insn), .younger_vld(younger_vld), .pat_en(pat_en),
    .fuse_o(fuse_o), .pat_o(pat_o), .rd_o(rd_o));

  function automatic logic [31:0] enc_i(logic [6:0] op, logic [2:0] f3, logic [4:0] rd,
                                        logic [4:0] rs1, logic [11:0] imm);
    return {imm, rs1, f3, rd, op};
  endfunction
  function automatic logic [31:0] enc_u(logic [6:0] op, logic [4:0] rd, logic [19:0] imm);
    return {imm, rd, op};
  endfunction
  function automatic logic [31:0] enc_sh(logic [2:0] f3, logic [4:0] rd, logic [4:0] rs1, logic [5:0] amt);
    return {6'd0, amt, rs1, f3, rd, 7'b0010011};
  endfunction
  function automatic logic [31:0] enc_add(logic [4:0] rd, logic [4:0] rs1, logic [4:0] rs2);
    return {7'd0, rs2, rs1, 3'b000, rd, 7'b0110011};
  endfunction

  task automatic step(logic [31:0] o, logic ov, logic [31:0] y, logic yv, logic [5:0] en);
    @(negedge clk);
    older_insn = o; older_vld = ov; younger_insn = y; younger_vld = yv; pat_en = en;
    @(posedge clk);
    #2;
  endtask

  task automatic expect_out(string tag, logic f, logic [2:0] p, logic [4:0] r);
    checks++;
    if (fuse_o !== f || pat_o !== p || rd_o !== r) begin
      errors++;
      $display("FAIL %s: got fuse=%0b pat=%0d rd=%0d, expected fuse=%0b pat=%0d rd=%0d",
               tag, fuse_o, pat_o, rd_o, f, p, r);
    end
  endtask

  task automatic t_reset();
    step(enc_u(7'b0110111, 5'd5, 20'h12345), 1, enc_i(7'b0010011, 3'b000, 5'd5, 5'd5, 12'h10), 1, 6'h3f);
    expect_out("R11 reset", 0, 0, 0);
    rst = 1'b0;
  endtask

  task automatic t_lui();
    step(enc_u(7'b0110111, 5'd5, 20'h12345), 1, enc_i(7'b0010011, 3'b000, 5'd5, 5'd5, 12'h678), 1, 6'h3f);
    expect_out("R1 lui+addi", 1, 1, 5);
    step(enc_u(7'b0110111, 5'd9, 20'h1), 1, enc_i(7'b0011011, 3'b000, 5'd9, 5'd9, 12'hfff), 1, 6'h3f);
    expect_out("R1 lui+addiw", 1, 1, 9);
  endtask

  task automatic t_auipc();
    step(enc_u(7'b0010111, 5'd7, 20'h4), 1, enc_i(7'b0010011, 3'b000, 5'd7, 5'd7, 12'h20), 1, 6'h3f);
    expect_out("R2 auipc+addi", 1, 2, 7);
    step(enc_u(7'b0010111, 5'd7, 20'h4), 1, enc_i(7'b0011011, 3'b000, 5'd7, 5'd7, 12'h20), 1, 6'h3f);
    expect_out("R2 auipc+addiw", 0, 0, 0);
  endtask

  task automatic t_zext_half();
    step(enc_sh(3'b001, 5'd10, 5'd11, 6'd48), 1, enc_sh(3'b101, 5'd10, 5'd10, 6'd48), 1, 6'h3f);
    expect_out("R3 zext half", 1, 3, 10);
    step(enc_sh(3'b001, 5'd10, 5'd11, 6'd48), 1, enc_sh(3'b101, 5'd10, 5'd10, 6'd47), 1, 6'h3f);
    expect_out("R3 amount mismatch", 0, 0, 0);
  endtask

  task automatic t_word_family();
    step(enc_sh(3'b001, 5'd12, 5'd3, 6'd32), 1, enc_sh(3'b101, 5'd12, 5'd12, 6'd32), 1, 6'h3f);
    expect_out("R4 zext word", 1, 4, 12);
    step(enc_sh(3'b001, 5'd12, 5'd3, 6'd32), 1, enc_sh(3'b101, 5'd12, 5'd12, 6'd31), 1, 6'h3f);
    expect_out("R5 shifted 31", 1, 5, 12);
    step(enc_sh(3'b001, 5'd12, 5'd3, 6'd32), 1, enc_sh(3'b101, 5'd12, 5'd12, 6'd0), 1, 6'h3f);
    expect_out("R5 shifted 0", 1, 5, 12);
    step(enc_sh(3'b001, 5'd12, 5'd3, 6'd32), 1, enc_sh(3'b101, 5'd12, 5'd12, 6'd33), 1, 6'h3f);
    expect_out("R5 shifted 33", 0, 0, 0);
    step(enc_sh(3'b001, 5'd12, 5'd3, 6'd32), 1, enc_sh(3'b101, 5'd12, 5'd12, 6'd32), 1, 6'h37);
    expect_out("R8 R4 masked", 0, 0, 0);
    step(enc_sh(3'b001, 5'd12, 5'd3, 6'd32), 1, enc_sh(3'b101, 5'd12, 5'd12, 6'd5), 1, 6'h37);
    expect_out("R8 R5 still on", 1, 5, 12);
  endtask

  task automatic t_add_ld();
    step(enc_add(5'd20, 5'd1, 5'd2), 1, enc_i(7'b0000011, 3'b011, 5'd20, 5'd20, 12'd0), 1, 6'h3f);
    expect_out("R6 add+ld", 1, 6, 20);
    step(enc_add(5'd20, 5'd1, 5'd2), 1, enc_i(7'b0000011, 3'b011, 5'd20, 5'd20, 12'd8), 1, 6'h3f);
    expect_out("R6 nonzero offset", 0, 0, 0);
  endtask

  task automatic t_link();
    step(enc_u(7'b0110111, 5'd5, 20'h1), 1, enc_i(7'b0010011, 3'b000, 5'd6, 5'd5, 12'h1), 1, 6'h3f);
    expect_out("R7 rd differs", 0, 0, 0);
    step(enc_add(5'd20, 5'd1, 5'd2), 1, enc_i(7'b0000011, 3'b011, 5'd20, 5'd21, 12'd0), 1, 6'h3f);
    expect_out("R7 rs1 differs", 0, 0, 0);
  endtask

  task automatic t_mask_all();
    for (int i = 0; i < 6; i++) begin
      step(enc_u(7'b0110111, 5'd5, 20'h1), 1, enc_i(7'b0010011, 3'b000, 5'd5, 5'd5, 12'h1), 1, 6'h3f & ~(6'd1 << i));
      if (i == 0) expect_out("R8 lui masked", 0, 0, 0);
      else expect_out("R8 other bit off", 1, 1, 5);
    end
  endtask

  task automatic t_x0_valid();
    step(enc_u(7'b0110111, 5'd0, 20'h1), 1, enc_i(7'b0010011, 3'b000, 5'd0, 5'd0, 12'h1), 1, 6'h3f);
    expect_out("R9 x0", 0, 0, 0);
    step(enc_u(7'b0110111, 5'd5, 20'h1), 0, enc_i(7'b0010011, 3'b000, 5'd5, 5'd5, 12'h1), 1, 6'h3f);
    expect_out("R9 older invalid", 0, 0, 0);
    step(enc_u(7'b0110111, 5'd5, 20'h1), 1, enc_i(7'b0010011, 3'b000, 5'd5, 5'd5, 12'h1), 0, 6'h3f);
    expect_out("R9 younger invalid", 0, 0, 0);
  endtask

  task automatic t_latency();
    step(enc_add(5'd31, 5'd1, 5'd2), 1, enc_i(7'b0000011, 3'b011, 5'd31, 5'd31, 12'd0), 1, 6'h3f);
    @(negedge clk);
    older_vld = 0;
    #1;
    expect_out("R10 held until edge", 1, 6, 31);
    @(posedge clk);
    #2;
    expect_out("R10 cleared next edge", 0, 0, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_lui();
    t_auipc();
    t_zext_half();
    t_word_family();
    t_add_ld();
    t_link();
    t_mask_all();
    t_x0_valid();
    t_latency();
    finish_run();
  end

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end
endmodule